// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital core of a successive-approximation analog-to-digital converter whose resolution is chosen at run time. A host writes an 8-bit control word over a parallel bus strobed by chip-select and write. The control word sets a multiplexer address, a signed or unsigned result, an 8- or 10-bit magnitude, and left or right justification of the output. When the write strobe is released, the core waits for the next falling edge of its own half-rate clock. It then holds an acquisition window and runs a bit-by-bit binary search. At each trial level the search is guided by a single external comparator decision.

When the search ends, an active-low interrupt is asserted. The host then reads the result as two bytes, high byte first, over the same bus. A write with read also held low starts a conversion again with the previous settings. The analog array, comparator and reference stay outside. The core exposes the trial code it is presenting so that the comparator can be driven.

Top module: `sar_seq_core`

## Requirements
- R1: A write (cs_n and wr_n low, rd_n high) latches the bus word: bits 4:0 give the multiplexer address shown on mux_addr, bit 5 = 1 selects unsigned, bit 6 = 1 selects 8-bit magnitude (0 selects 10-bit), bit 7 = 1 selects left justification.
- R2: After reset int_n is high, dout_oe is low and mux_addr is zero.
- R3: Releasing the write strobe (wr_n or cs_n rising after both were low) sets a start flag. Acquisition (acq_o high) begins only on a half-rate falling edge after the flag is set. If the flag lands on such an edge, that edge is missed and acquisition begins two input clocks later.
- R4: Acquisition lasts 3 half-rate periods. Conversion then lasts W half-rate periods, where W is 8, 9, 10 or 11 for 8-bit, 8-bit signed, 10-bit and 10-bit signed. Counted in input clocks from the first clock edge after the strobe release to int_n low, the latency is 2W+8 or 2W+9, depending on the half-rate phase. Both values occur.
- R5: int_n goes low only on a half-rate falling edge, at completion. The next falling edge of rd_n, with cs_n low and wr_n high, returns it high.
- R6: Bits are decided one per half-rate period, MSB first, against comparator input cmp_i (1 = input at or above the trial level). The trial code on trial_o is offset binary in the low W bits. In signed modes the top bit is the sign, decided first. The result is the input value clamped to the code range: two's complement in signed modes.
- R7: In unsigned mode a negative input yields an all-zeros result.
- R8: The first read after completion gives the high byte and the second gives the low byte. Right-justified results are sign-extended (signed) or zero-extended (unsigned) to 16 bits. Left-justified results have their MSB at bit 15 and zeros below. dout_oe is high only while cs_n and rd_n are both low.
- R9: A write with cs_n, wr_n and rd_n all low starts a conversion and leaves address, resolution, sign and justification unchanged.
- R10: A new conversion may start after only the first byte is read. Its completion replaces the result and sends the next read back to the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| din | input | 8 | Control word from the host bus |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| dout | output | 8 | Result byte toward the host bus |
| dout_oe | output | 1 | Bus drive enable for dout |
| int_n | output | 1 | Conversion-complete interrupt, active low |
| mux_addr | output | 5 | Latched multiplexer address |
| trial_o | output | 11 | Trial code presented to the comparator |
| acq_o | output | 1 | High during the acquisition window |

## Verification
The bench builds the core with its default parameters: 10-bit and 8-bit magnitudes plus an optional sign, a 3-period acquisition window and 16-bit result words. It sweeps all eight combinations of width, sign and justification, so both the shortest (8-bit) and longest (11-bit) searches and both byte layouts are covered. Random idle gaps between conversions place the start in both half-rate phases, so both latency values can be seen. Clamp values at each end of every code range, as well as negative inputs in unsigned mode, are reached directly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV} sar_state_e;

  typedef struct packed {
    logic       left;
    logic       res8;
    logic       unsgn;
    logic [4:0] addr;
  } sar_cfg_t;

  // Number of decided bits for a given mode
  function automatic logic [3:0] code_width(input logic res8, input logic unsgn,
                                            input int hi_bits, input int lo_bits);
    int w;
    w = (res8 ? lo_bits : hi_bits) + (unsgn ? 0 : 1);
    return 4'(w);
  endfunction

  // Place a finished offset-binary code into a 16-bit justified word
  function automatic logic [15:0] place_word(input logic [10:0] raw, input logic [3:0] w,
                                             input logic sgn, input logic left);
    logic [10:0] tc;
    logic [15:0] v;
    logic        msb;
    tc  = sgn ? (raw ^ (11'd1 << (w - 4'd1))) : raw;
    msb = tc[w - 4'd1];
    for (int i = 0; i < 16; i++) begin
      if (i < int'(w)) v[i] = tc[i];
      else             v[i] = sgn & msb;
    end
    if (left) v = v << (5'd16 - 5'(w));
    return v;
  endfunction

endpackage

// File: rtl/sar_halfrate.sv
module sar_halfrate (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic ph_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end
  // edge at which the half-rate clock falls
  assign tick = ph_q;
endmodule

// File: rtl/sar_host_if.sv
module sar_host_if
  import sar_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic [7:0] din,
  output sar_cfg_t   cfg,
  output logic       start_req,
  output logic       rd_fall,
  output logic       rd_end
);
  logic wr_act, rd_act, wr_act_q, rd_act_q;

  assign wr_act = !cs_n && !wr_n;
  assign rd_act = !cs_n && !rd_n && wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act && rd_n) cfg <= sar_cfg_t'(din);
    end
  end

  assign start_req = wr_act_q && !wr_act;
  assign rd_fall   = rd_act && !rd_act_q;
  assign rd_end    = rd_act_q && !rd_act;
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_seq_pkg::*;
#(
  parameter int HI_BITS   = 10,
  parameter int LO_BITS   = 8,
  parameter int ACQ_HALF  = 3,
  localparam int MAX_W    = HI_BITS + 1,
  localparam int HC_W     = (ACQ_HALF > 1) ? $clog2(ACQ_HALF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_req,
  input  logic             cfg_res8,
  input  logic             cfg_unsgn,
  input  logic             cfg_left,
  input  logic             cmp_i,
  output logic [MAX_W-1:0] trial,
  output logic             acq,
  output logic             done_evt,
  output logic [MAX_W-1:0] res_next,
  output logic [3:0]       w_q,
  output logic             sgn_q,
  output logic             left_q
);
  sar_state_e      state;
  logic [HC_W-1:0] hcnt;
  logic [3:0]      idx;
  logic            pend;

  always_comb begin
    res_next = trial;
    res_next[idx] = cmp_i;
    if (idx != 4'd0) res_next[idx - 4'd1] = 1'b1;
  end

  assign done_evt = (state == ST_CONV) && tick && (idx == 4'd0);
  assign acq      = (state == ST_ACQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hcnt   <= '0;
      idx    <= '0;
      trial  <= '0;
      pend   <= 1'b0;
      w_q    <= 4'(HI_BITS + 1);
      sgn_q  <= 1'b1;
      left_q <= 1'b0;
    end else begin
      if (start_req) pend <= 1'b1;
      unique case (state)
        ST_IDLE: if (pend && tick) begin
          state  <= ST_ACQ;
          hcnt   <= '0;
          pend   <= start_req;
          w_q    <= code_width(cfg_res8, cfg_unsgn, HI_BITS, LO_BITS);
          sgn_q  <= !cfg_unsgn;
          left_q <= cfg_left;
        end
        ST_ACQ: if (tick) begin
          if (hcnt == HC_W'(ACQ_HALF - 1)) begin
            state <= ST_CONV;
            idx   <= w_q - 4'd1;
            trial <= MAX_W'(1) << (w_q - 4'd1);
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_CONV: if (tick) begin
          trial <= res_next;
          if (idx == 4'd0) state <= ST_IDLE;
          else             idx   <= idx - 4'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_out.sv
module sar_out
  import sar_seq_pkg::*;
#(
  parameter int MAX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  logic [MAX_W-1:0] res_next,
  input  logic [3:0]       w_q,
  input  logic             sgn_q,
  input  logic             left_q,
  input  logic             rd_fall,
  input  logic             rd_end,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [7:0]       dout,
  output logic             dout_oe,
  output logic             int_n,
  output logic             byte_sel
);
  logic [15:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      int_n    <= 1'b1;
      byte_sel <= 1'b0;
    end else begin
      if (done_evt) begin
        word_q   <= place_word(11'(res_next), w_q, sgn_q, left_q);
        int_n    <= 1'b0;
        byte_sel <= 1'b0;
      end else begin
        if (rd_fall) int_n    <= 1'b1;
        if (rd_end)  byte_sel <= ~byte_sel;
      end
    end
  end

  assign dout    = byte_sel ? word_q[7:0] : word_q[15:8];
  assign dout_oe = !cs_n && !rd_n;
endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core
  import sar_seq_pkg::*;
#(
  parameter int HI_BITS  = 10,
  parameter int LO_BITS  = 8,
  parameter int ACQ_HALF = 3,
  localparam int MAX_W   = HI_BITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [7:0]       din,
  input  logic             cmp_i,
  output logic [7:0]       dout,
  output logic             dout_oe,
  output logic             int_n,
  output logic [4:0]       mux_addr,
  output logic [MAX_W-1:0] trial_o,
  output logic             acq_o
);
  sar_cfg_t         cfg;
  logic             tick_w, start_w, rd_fall_w, rd_end_w, done_w;
  logic [MAX_W-1:0] res_w;
  logic [3:0]       w_w;
  logic             sgn_w, left_w, byte_sel_w;

  sar_halfrate u_half (.clk(clk), .rst_n(rst_n), .tick(tick_w));

  sar_host_if u_host (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .cfg(cfg), .start_req(start_w), .rd_fall(rd_fall_w), .rd_end(rd_end_w));

  sar_engine #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS), .ACQ_HALF(ACQ_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .start_req(start_w),
    .cfg_res8(cfg.res8), .cfg_unsgn(cfg.unsgn), .cfg_left(cfg.left), .cmp_i(cmp_i),
    .trial(trial_o), .acq(acq_o), .done_evt(done_w), .res_next(res_w),
    .w_q(w_w), .sgn_q(sgn_w), .left_q(left_w));

  sar_out #(.MAX_W(MAX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .done_evt(done_w), .res_next(res_w), .w_q(w_w),
    .sgn_q(sgn_w), .left_q(left_w), .rd_fall(rd_fall_w), .rd_end(rd_end_w),
    .cs_n(cs_n), .rd_n(rd_n), .dout(dout), .dout_oe(dout_oe), .int_n(int_n),
    .byte_sel(byte_sel_w));

  assign mux_addr = cfg.addr;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       acq,
  input logic       int_n,
  input logic       byte_sel,
  input logic       cs_n,
  input logic       wr_n,
  input logic       rd_n,
  input logic [4:0] mux_addr
);
  // R5
  int_on_half_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(tick));

  // R3
  acq_on_half_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq) |-> $past(tick));

  // R9
  restart_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && !rd_n) |=> $stable(mux_addr));

  // R10
  ptr_reset_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> !byte_sel);

  // R5
  int_release_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> $past(!cs_n && !rd_n && wr_n));
endmodule

bind sar_seq_core sar_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .acq(acq_o), .int_n(int_n),
  .byte_sel(byte_sel_w), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .mux_addr(mux_addr));

// File: tb/sar_seq_core_tb.sv
module sar_seq_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0]  din = '0;
  logic        cmp;
  logic [7:0]  dout;
  logic        dout_oe, int_n, acq;
  logic [4:0]  mux_addr;
  logic [10:0] trial;

  int n_chk = 0, n_err = 0;
  int v_in = 0, b_w = 11, lvl;
  bit b_sgn = 1, b_left = 0;
  bit seen_short = 0, seen_long = 0;

  always #10 clk = ~clk;

  sar_seq_core dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .cmp_i(cmp), .dout(dout), .dout_oe(dout_oe), .int_n(int_n), .mux_addr(mux_addr),
    .trial_o(trial), .acq_o(acq));

  // comparator model: input value against the level the trial code stands for
  always_comb begin
    lvl = int'({21'd0, trial});
    if (b_sgn) lvl = lvl - (1 << (b_w - 1));
    cmp = (v_in >= lvl);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_word(input int v, input int w, input bit sgn, input bit left);
    int lo, hi, c;
    lo = sgn ? -(1 << (w - 1)) : 0;
    hi = sgn ? (1 << (w - 1)) - 1 : (1 << w) - 1;
    c  = (v < lo) ? lo : (v > hi) ? hi : v;
    if (left) return (c << (16 - w)) & 32'hFFFF;
    return c & 32'hFFFF;
  endfunction

  task automatic bus_write(input logic [7:0] d, input bit keep);
    @(negedge clk);
    cs_n = 0; wr_n = 0; rd_n = keep ? 1'b0 : 1'b1; din = d;
    @(negedge clk);
    wr_n = 1; cs_n = 1; rd_n = 1;
  endtask

  task automatic wait_int(output int cnt);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (!int_n) return;
    end
    cnt = -1;
  endtask

  task automatic bus_read(output logic [7:0] b);
    @(negedge clk);
    cs_n = 0; rd_n = 0;
    #2;
    b = dout;
    chk(dout_oe === 1'b1, "R8 oe during read", int'(dout_oe), 1);
    @(negedge clk);
    cs_n = 1; rd_n = 1;
    #2;
  endtask

  task automatic convert(input logic [7:0] cfgw, input int v, input bit keep, input bit read_all);
    int cnt, ew;
    logic [7:0] b1, b2;
    if (!keep) begin
      b_left = cfgw[7];
      b_sgn  = !cfgw[5];
      b_w    = (cfgw[6] ? 8 : 10) + (b_sgn ? 1 : 0);
    end
    v_in = v;
    bus_write(cfgw, keep);
    wait_int(cnt);
    chk(cnt == 2*b_w + 8 || cnt == 2*b_w + 9, "R4 latency", cnt, 2*b_w + 8);
    if (cnt == 2*b_w + 8) seen_short = 1;
    if (cnt == 2*b_w + 9) seen_long = 1;
    if (!read_all) return;
    bus_read(b1);
    chk(int_n === 1'b1, "R5 int released by read", int'(int_n), 1);
    bus_read(b2);
    ew = exp_word(v, b_w, b_sgn, b_left);
    chk({b1, b2} == 16'(ew), "R6 R8 result word", int'({b1, b2}), ew);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] cw, b1, b2;
    int v, ew, cnt;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(int_n === 1'b1, "R2 int_n", int'(int_n), 1);
    chk(dout_oe === 1'b0, "R2 dout_oe", int'(dout_oe), 0);
    chk(mux_addr === 5'd0, "R2 mux_addr", int'(mux_addr), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1: address field lands on mux_addr
    bus_write(8'b0001_0110, 0); b_w = 11; b_sgn = 1; b_left = 0;
    wait_int(cnt);
    chk(mux_addr == 5'd22, "R1 address", int'(mux_addr), 22);
    bus_read(b1); bus_read(b2);

    // directed: every mode, both range ends, zero and minus one
    for (int m = 0; m < 8; m++) begin
      cw = {m[2], m[1], m[0], 5'd3};
      convert(cw, 5000, 0, 1);
      convert(cw, -5000, 0, 1);
      convert(cw, 0, 0, 1);
      convert(cw, -1, 0, 1);
    end

    // R7 unsigned negative gives zeros
    convert(8'b0010_0000, -77, 0, 1);
    // R6 signed 10-bit right-justified, example value
    convert(8'b0000_0001, -300, 0, 1);

    // R9 restart keeps the previous settings
    convert(8'b1000_1001, 123, 0, 1);
    convert(8'b0111_0110, 45, 1, 1);
    chk(mux_addr == 5'd9, "R9 address kept", int'(mux_addr), 9);

    // R10 new conversion after only the first byte
    convert(8'b0000_0000, 700, 0, 0);
    bus_read(b1);
    chk(b1 == 8'h02, "R10 first byte of old result", int'(b1), 2);
    convert(8'b0000_0000, -200, 0, 1);

    // R8 no drive outside reads
    chk(dout_oe === 1'b0, "R8 oe idle", int'(dout_oe), 0);

    // random mix with random idle gaps for the half-rate phase (R3)
    for (int r = 0; r < 50; r++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      cw = 8'($urandom_range(0, 255));
      v  = int'($urandom_range(0, 2600)) - 1300;
      convert(cw, v, 0, 1);
      chk(mux_addr == cw[4:0], "R1 address random", int'(mux_addr), int'(cw[4:0]));
    end

    // R3 R4: both phases of the half-rate clock were met
    chk(seen_short, "R3 short latency seen", int'(seen_short), 1);
    chk(seen_long, "R3 long latency seen", int'(seen_long), 1);
    ew = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err + ew);
    $finish;
  end
endmodule